// File: doc/BRIEF.md
# Oscillator Frequency Detector

This block identifies which crystal is attached to a chip by timing its oscillator against a slow 32.768 kHz reference. The block runs entirely on the oscillator clock. The reference passes through a two-flop synchroniser, and its rising edges open and close a counting window. The window length is set by software as a number of reference periods. While the window is open, the block counts oscillator cycles. The count saturates rather than wrapping.

When the window closes, the count is compared against four supported crystal bands: 12, 13, 19.2 and 26 MHz. Each band has a fixed tolerance, scaled to the chosen window length. On a match, the block rewrites a 2-bit frequency code inside an oscillator-control word and sets a valid flag. On a miss, it clears the valid flag and keeps the previous code. Software reaches the block through a simple word-wide read/write port with three registers.

Top module: `osc_freq_detect`

## Requirements
- R1: After reset the block is idle (busy 0), the count is 0, the valid flag is 0, the latched window is 0, and the oscillator-control word is 0x0000_0000. Its frequency code is therefore 0, the 13 MHz code.
- R2: The register map is as follows.
  - Address 0 (control): writing bit 31 as 1 starts a measurement, and bits 3:0 give the window setting N. A read returns the latched N in bits 3:0 and zeros elsewhere.
  - Address 1 (status): bit 31 is busy, bit 30 is valid, and bits 15:0 are the count. All other bits read 0.
  - Address 2 (oscillator-control word): the frequency code sits in bits 3:2.
  - Address 3 reads 0.
- R3: Busy rises on the clock edge that accepts a start. It falls on the edge where the window closes, and the count holds its final value in that same cycle.
- R4: The count is the number of oscillator cycles between the detected reference rise that opens the window and the (N+1)-th detected rise after it. The reference is sampled through a two-flop synchroniser before edge detection. While idle, the count stays frozen.
- R5: The count saturates at 0xFFFF instead of wrapping.
- R6: With N=1, the bands (inclusive) map to these codes:

  | Count range | Frequency | Code |
  |---|---|---|
  | 791..797 | 13 MHz | 0 |
  | 1169..1175 | 19.2 MHz | 1 |
  | 729..735 | 12 MHz | 2 |
  | 1584..1590 | 26 MHz | 3 |

- R7: For any N, a band with centre C matches when |2*count - C*(N+1)| <= 6.
- R8: On a match, the code field and a valid flag of 1 appear one cycle after busy falls. All other bits of the oscillator-control word keep their values.
- R9: On a miss, the valid flag becomes 0 and the code field keeps its value.
- R10: A start written while busy is ignored. The running measurement and its latched window are unaffected.
- R11: A software write to address 2 stores all 32 bits, including the code field. The new value is visible on the next cycle and on the code output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock being measured |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | 32.768 kHz reference, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational) |
| busy_o | output | 1 | Measurement in progress |
| freq_code_o | output | 2 | Current oscillator frequency code |
| code_valid_o | output | 1 | Last measurement matched a band |

## Verification
The main function is driven with reference trains of chosen rise-to-rise gaps.

- Exact band centres check the code mapping.
- Counts at the ±3 edges, including uneven gap pairs, check the inclusive tolerance.
- A count 4 beyond a band separates a hit from a miss.
- A longer window separates correct scaling from a fixed-band classifier.
- A very long window checks saturation against wrapping.
- A start issued mid-measurement, and a word preloaded with ones, check that retriggers and the bits outside the code field are left alone.

A cycle-level model in the bench follows busy, read data and the code on every clock.

// File: rtl/osc_det_pkg.sv
package osc_det_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } meas_st_e;

  localparam int NUM_BANDS = 4;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int CODE_W    = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_OSC  = 2'd2;

  localparam int START_BIT = 31;
  localparam logic [CODE_W-1:0] CODE_13M = 2'd0;

  // nominal count for a two-period window, per band
  function automatic int band_center(input int k);
    case (k)
      0:       return 732;
      1:       return 794;
      2:       return 1172;
      default: return 1587;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] band_code(input int k);
    case (k)
      0:       return 2'd2;
      1:       return 2'd0;
      2:       return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/osc_det_sync.sv
module osc_det_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/osc_det_meas.sv
module osc_det_meas
  import osc_det_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             rise_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o,
  output logic [WIN_W-1:0] win_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meas_st_e         state_q;
  logic [CNT_W-1:0] count_q;
  logic [WIN_W-1:0] edges_q;
  logic [WIN_W-1:0] win_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      edges_q <= '0;
      win_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ARM;
            win_q   <= win_i;
            count_q <= '0;
          end
        end
        ST_ARM: begin
          if (rise_i) begin
            state_q <= ST_COUNT;
            edges_q <= '0;
          end
        end
        ST_COUNT: begin
          if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
          if (rise_i) begin
            if (edges_q == win_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              edges_q <= edges_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign count_o = count_q;
  assign win_o   = win_q;
endmodule

// File: rtl/osc_det_classify.sv
module osc_det_classify
  import osc_det_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN_W = 4,
  parameter int TOL   = 3
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WIN_W-1:0]  win_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int PW = CNT_W + WIN_W + 2;

  logic [NUM_BANDS-1:0] band_hit;
  logic [PW-1:0]        twice;

  assign twice = {{(PW-CNT_W-1){1'b0}}, count_i, 1'b0};

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
    localparam int CENTER = band_center(k);
    logic [PW-1:0] target;
    logic [PW-1:0] diff;
    assign target = PW'(CENTER) * (PW'(win_i) + PW'(1));
    assign diff   = (twice >= target) ? (twice - target) : (target - twice);
    assign band_hit[k] = (diff <= PW'(2 * TOL));
  end

  always_comb begin
    code_o = CODE_13M;
    for (int k = NUM_BANDS - 1; k >= 0; k--) begin
      if (band_hit[k]) code_o = band_code(k);
    end
  end

  assign hit_o = |band_hit;
endmodule

// File: rtl/osc_det_regs.sv
module osc_det_regs
  import osc_det_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WIN_W    = 4,
  parameter int CODE_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] class_code_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WIN_W-1:0]  win_i,
  output logic              start_o,
  output logic [WIN_W-1:0]  win_wr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);
  localparam logic [DATA_W-1:0] OSC_RST = '0;

  logic [DATA_W-1:0] osc_q;
  logic              valid_q;

  assign start_o  = wr_en_i && (addr_i == ADDR_CTRL) && wdata_i[START_BIT];
  assign win_wr_o = wdata_i[WIN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q   <= OSC_RST;
      valid_q <= 1'b0;
    end else begin
      if (wr_en_i && (addr_i == ADDR_OSC)) osc_q <= wdata_i;
      if (done_i) begin
        valid_q <= hit_i;
        if (hit_i) osc_q[CODE_LSB +: CODE_W] <= class_code_i;
      end
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = {{(DATA_W-WIN_W){1'b0}}, win_i};
      ADDR_STAT: rdata_o = {busy_i, valid_q, {(DATA_W-2-CNT_W){1'b0}}, count_i};
      ADDR_OSC:  rdata_o = osc_q;
      default:   rdata_o = '0;
    endcase
  end

  assign code_o  = osc_q[CODE_LSB +: CODE_W];
  assign valid_o = valid_q;
endmodule

// File: rtl/osc_freq_detect.sv
module osc_freq_detect
  import osc_det_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WIN_W       = 4,
  parameter int TOL         = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_LSB    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_clk_i,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        busy_o,
  output logic [1:0]  freq_code_o,
  output logic        code_valid_o
);
  logic              ref_rise;
  logic              start;
  logic [WIN_W-1:0]  win_wr;
  logic              meas_busy;
  logic              meas_done;
  logic [CNT_W-1:0]  meas_count;
  logic [WIN_W-1:0]  meas_win;
  logic              class_hit;
  logic [CODE_W-1:0] class_code;

  osc_det_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ref_clk_i),
    .rise_o (ref_rise)
  );

  osc_det_meas #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_meas (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .win_i  (win_wr),
    .rise_i (ref_rise),
    .busy_o (meas_busy),
    .done_o (meas_done),
    .count_o(meas_count),
    .win_o  (meas_win)
  );

  osc_det_classify #(.CNT_W(CNT_W), .WIN_W(WIN_W), .TOL(TOL)) u_class (
    .count_i(meas_count),
    .win_i  (meas_win),
    .hit_o  (class_hit),
    .code_o (class_code)
  );

  osc_det_regs #(.CNT_W(CNT_W), .WIN_W(WIN_W), .CODE_LSB(CODE_LSB)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .busy_i      (meas_busy),
    .done_i      (meas_done),
    .hit_i       (class_hit),
    .class_code_i(class_code),
    .count_i     (meas_count),
    .win_i       (meas_win),
    .start_o     (start),
    .win_wr_o    (win_wr),
    .rdata_o     (rdata_o),
    .code_o      (freq_code_o),
    .valid_o     (code_valid_o)
  );

  assign busy_o = meas_busy;
endmodule

// File: rtl/osc_freq_detect_chk.sv
module osc_freq_detect_chk #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             hit_i,
  input logic             valid_i,
  input logic [CNT_W-1:0] count_i,
  input logic [WIN_W-1:0] win_i,
  input logic [1:0]       class_code_i,
  input logic [1:0]       code_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sw_wr;
  assign sw_wr = wr_en_i && (addr_i == 2'd2);

  a_r3_done_only_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  a_r4_idle_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $past(!busy_i)) |-> $stable(count_i));

  a_r5_count_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && ($past(count_i) == CNT_MAX)) |-> (count_i == CNT_MAX));

  a_r10_window_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(win_i));

  a_r8_match_updates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_i && hit_i && !sw_wr) |-> (valid_i && (code_i == $past(class_code_i))));

  a_r9_miss_keeps_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_i && !hit_i && !sw_wr) |-> (!valid_i && $stable(code_i)));

  a_r9_code_changes_only_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!done_i && !sw_wr) |-> $stable(code_i));
endmodule

bind osc_freq_detect osc_freq_detect_chk #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .busy_i      (meas_busy),
  .done_i      (meas_done),
  .hit_i       (class_hit),
  .valid_i     (code_valid_o),
  .count_i     (meas_count),
  .win_i       (meas_win),
  .class_code_i(class_code),
  .code_i      (freq_code_o)
);

// File: tb/tb_osc_freq_detect.sv
`timescale 1ns/1ps
module tb_osc_freq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy;
  logic [1:0]  freq_code;
  logic        code_valid;

  int tests = 0;
  int fails = 0;
  int cyc_fail_prints = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  osc_freq_detect dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_clk_i   (ref_clk),
    .wr_en_i     (wr_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .busy_o      (busy),
    .freq_code_o (freq_code),
    .code_valid_o(code_valid)
  );

  // reference generator: each entry is a rise-to-rise gap in clk cycles
  int gapq[$];
  initial begin
    forever begin
      @(negedge clk);
      if (gapq.size() > 0) begin
        int g;
        g = gapq.pop_front();
        ref_clk = 1'b1;
        repeat (g / 2) @(negedge clk);
        ref_clk = 1'b0;
        repeat (g - g / 2 - 1) @(negedge clk);
      end
    end
  end

  // behavioural reference model
  bit          m_s1, m_s2, m_s3, m_rise, m_pend, m_valid, m_hit;
  int          m_state, m_cnt, m_edges, m_win, m_code;
  logic [31:0] m_osc, m_osc_n;

  function automatic void classify(input int c, input int w, output bit hit, output int code);
    int cen[4];
    int cd[4];
    cen = '{732, 794, 1172, 1587};
    cd  = '{2, 0, 1, 3};
    hit = 0;
    code = 0;
    for (int k = 0; k < 4; k++) begin
      int d;
      d = 2 * c - cen[k] * (w + 1);
      if (d < 0) d = -d;
      if (!hit && d <= 6) begin
        hit = 1;
        code = cd[k];
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pend = 0; m_valid = 0;
      m_state = 0; m_cnt = 0; m_edges = 0; m_win = 0; m_osc = '0;
    end else begin
      m_rise = m_s2 && !m_s3;
      m_osc_n = (wr_en && addr == 2'd2) ? wdata : m_osc;
      if (m_pend) begin
        classify(m_cnt, m_win, m_hit, m_code);
        m_valid = m_hit;
        if (m_hit) m_osc_n[3:2] = 2'(m_code);
      end
      m_pend = 0;
      case (m_state)
        0: if (wr_en && addr == 2'd0 && wdata[31]) begin
             m_state = 1; m_win = int'(wdata[3:0]); m_cnt = 0;
           end
        1: if (m_rise) begin m_state = 2; m_edges = 0; end
        default: begin
          if (m_cnt < 65535) m_cnt++;
          if (m_rise) begin
            if (m_edges == m_win) begin m_state = 0; m_pend = 1; end
            else m_edges++;
          end
        end
      endcase
      m_osc = m_osc_n;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_clk;
    end
  end

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return 32'(m_win);
      2'd1:    return {m_state != 0, m_valid, 14'b0, 16'(m_cnt)};
      2'd2:    return m_osc;
      default: return '0;
    endcase
  endfunction

  // per-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && !finished) begin
        tests++;
        if (rdata !== exp_read(addr) || busy !== (m_state != 0) ||
            freq_code !== m_osc[3:2] || code_valid !== m_valid) begin
          fails++;
          if (cyc_fail_prints < 20) begin
            cyc_fail_prints++;
            $display("FAIL R3 R4 R8 cycle compare: rdata=%h/%h busy=%b/%b code=%0d/%0d valid=%b/%b (act/exp)",
                     rdata, exp_read(addr), busy, m_state != 0, freq_code, m_osc[3:2],
                     code_valid, m_valid);
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd1; wdata = '0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic push_gaps(input int win, input int pa, input int pb);
    for (int i = 0; i <= win; i++) gapq.push_back((i % 2 == 0) ? pa : pb);
    gapq.push_back(20);
  endtask

  task automatic wait_meas();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    while (gapq.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_meas(input int win, input int pa, input int pb);
    write_reg(2'd0, 32'h8000_0000 | 32'(win));
    push_gaps(win, pa, pb);
    wait_meas();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    read_reg(2'd1, d); chk("R1 status after reset", d, 32'h0);
    read_reg(2'd2, d); chk("R1 osc word after reset", d, 32'h0);
    read_reg(2'd0, d); chk("R1 window after reset", d, 32'h0);
    chk("R1 code output after reset", {30'b0, freq_code}, 32'd0);
    read_reg(2'd3, d); chk("R2 unused address reads zero", d, 32'h0);

    // R3 busy follows trigger
    write_reg(2'd0, 32'h8000_0001);
    chk("R3 busy after start", {31'b0, busy}, 32'd1);
    push_gaps(1, 397, 397);
    wait_meas();
    read_reg(2'd1, d); chk("R4 R6 13 MHz centre count", d, 32'h4000_0000 | 32'd794);
    read_reg(2'd2, d); chk("R6 R8 13 MHz code", d, 32'h0);
    read_reg(2'd0, d); chk("R2 window readback", d, 32'd1);

    run_meas(1, 366, 366);
    read_reg(2'd2, d); chk("R6 12 MHz code", d, 32'h8);

    run_meas(1, 587, 588);
    read_reg(2'd1, d); chk("R4 uneven gaps count", d, 32'h4000_0000 | 32'd1175);
    read_reg(2'd2, d); chk("R6 19.2 MHz upper edge", d, 32'h4);

    run_meas(1, 793, 794);
    read_reg(2'd2, d); chk("R6 26 MHz code", d, 32'hC);

    // R9 miss by 4 keeps previous code
    run_meas(1, 368, 368);
    read_reg(2'd1, d); chk("R9 miss clears valid", d, 32'd736);
    read_reg(2'd2, d); chk("R9 miss keeps code", d, 32'hC);

    run_meas(1, 364, 365);
    read_reg(2'd2, d); chk("R6 12 MHz lower edge", d, 32'h8);

    // R11 software write, R8 other bits preserved
    write_reg(2'd2, 32'hFFFF_FFF3);
    read_reg(2'd2, d); chk("R11 software write", d, 32'hFFFF_FFF3);
    chk("R11 code output follows write", {30'b0, freq_code}, 32'd0);
    run_meas(1, 586, 586);
    read_reg(2'd2, d); chk("R8 only code field rewritten", d, 32'hFFFF_FFF7);

    // R7 scaled window, N=3
    run_meas(3, 397, 397);
    read_reg(2'd1, d); chk("R4 R7 four-period count", d, 32'h4000_0000 | 32'd1588);
    read_reg(2'd2, d); chk("R7 scaled band match", d, 32'hFFFF_FFF3);

    // R10 retrigger ignored
    write_reg(2'd0, 32'h8000_0001);
    push_gaps(1, 366, 366);
    repeat (300) @(negedge clk);
    write_reg(2'd0, 32'h8000_0005);
    read_reg(2'd0, d); chk("R10 window unchanged by retrigger", d, 32'd1);
    wait_meas();
    read_reg(2'd1, d); chk("R10 count unaffected by retrigger", d, 32'h4000_0000 | 32'd732);
    read_reg(2'd2, d); chk("R10 code after retrigger", d, 32'hFFFF_FFFB);

    // R5 saturation
    run_meas(15, 4200, 4200);
    read_reg(2'd1, d); chk("R5 count saturates", d, 32'h0000_FFFF);
    read_reg(2'd2, d); chk("R5 R9 saturated miss keeps code", d, 32'hFFFF_FFFB);

    finish_run();
  end
endmodule